// File: doc/BRIEF.md
# Boot-Remappable Bus Address Decoder

This block is the first address-decode stage for a single bus master. It splits the 32-bit byte address into sixteen 256 MB banks by the top four address bits. Each bank is steered to one of these targets: the on-chip memories, one of eight external chip selects, the peripheral bridge, or an abort response for space that has no slave. Inside the on-chip bank, the eight address bits above the 1 MB boundary pick a second-level target. That target is the boot window, a ROM alias, or one of two SRAM aliases.

The boot window, which covers the first megabyte of the map, can point at three targets. Two controls choose among them. A boot-mode pin is latched on every clock edge while reset is held and is frozen once reset is released. A remap bit starts at 0 and is loaded by software through a one-cycle write port. Every select, and the abort flag, is combinational from the address and is gated by the transfer-valid strobe.

Top module: `boot_addr_decoder`

## Requirements
- R1: Banks 1 through 8 (addr[31:28] = 1..8) assert sel_ext bit (bank − 1). Bit 0 is chip select 0 and bit 7 is chip select 7.
- R2: Bank 15 (addr[31:28] = 15) asserts sel_periph.
- R3: Banks 9 through 14 assert abort and no select.
- R4: In bank 0, the sub-region index addr[27:20] = 1 selects the ROM, 2 selects SRAM0 and 3 selects SRAM1. This holds for every remap and boot-pin setting, and addr[19:0] has no effect on the choice.
- R5: In bank 0, any sub-region index from 4 to 255 asserts abort.
- R6: The boot window is bank 0 with sub-region index 0. With remap = 0 and the boot pin latched as 1, the boot window selects the ROM.
- R7: With remap = 0 and the boot pin latched as 0, the boot window asserts sel_ext bit 0.
- R8: With remap = 1, the boot window selects SRAM0, whatever the latched boot pin.
- R9: The boot pin is sampled only on clock edges while rst_n is low. Changes on the pin after reset is released have no effect on the boot window.
- R10: remap resets to 0. At a rising clock edge where remap_wr_en is 1, remap takes the value of remap_wr_data; otherwise remap holds its value.
- R11: While xfer_valid is 0, every select and abort is 0.
- R12: While xfer_valid is 1, exactly one of the select bits and the abort flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the boot pin is sampled while it is low |
| boot_pin | input | 1 | Boot-mode strap: 1 boots from ROM, 0 boots from external chip select 0 |
| remap_wr_en | input | 1 | Write strobe for the remap bit |
| remap_wr_data | input | 1 | New remap value |
| xfer_valid | input | 1 | The address carries a valid transfer |
| addr | input | 32 | Byte address |
| sel_rom | output | 1 | ROM select |
| sel_sram0 | output | 1 | First SRAM select |
| sel_sram1 | output | 1 | Second SRAM select |
| sel_ext | output | 8 | External chip selects, bit n = chip select n |
| sel_periph | output | 1 | Peripheral bridge select |
| abort | output | 1 | Unmapped access; abort to the master |

## Verification
The bench probes the edges of each decode range. It drives banks 8, 9, 14 and 15, and bank-0 sub-regions 3 and 4. An off-by-one in the external range would show up there as a stray chip select or a missing abort. It walks the boot window through all four remap and boot-pin combinations, and repeats this after a fresh reset with the opposite strap. A design that latched the pin continuously, or ignored remap, would send the window to the wrong slave. It also toggles the pin after reset and checks that the fixed aliases never move when the window does. Random addresses with a random valid strobe check that selects stay silent when idle and that exactly one target is active otherwise.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;

  typedef enum logic [2:0] {
    TGT_ROM    = 3'd0,
    TGT_SRAM0  = 3'd1,
    TGT_SRAM1  = 3'd2,
    TGT_EXT    = 3'd3,
    TGT_PERIPH = 3'd4,
    TGT_ABORT  = 3'd5
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [7:0] ext_idx;
  } route_t;

  // Sub-region indices inside the on-chip bank
  localparam int unsigned SUB_BOOT  = 0;
  localparam int unsigned SUB_ROM   = 1;
  localparam int unsigned SUB_SRAM0 = 2;
  localparam int unsigned SUB_SRAM1 = 3;

  // Target of the boot window given the two steering controls
  function automatic route_t boot_route(input logic remap, input logic boot_rom);
    route_t r;
    r.ext_idx = 8'd0;
    if (remap)         r.tgt = TGT_SRAM0;
    else if (boot_rom) r.tgt = TGT_ROM;
    else               r.tgt = TGT_EXT;
    return r;
  endfunction

  function automatic route_t fixed_route(input tgt_e t);
    route_t r;
    r.tgt     = t;
    r.ext_idx = 8'd0;
    return r;
  endfunction

endpackage

// File: rtl/boot_cfg_regs.sv
module boot_cfg_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_pin,
  input  logic wr_en,
  input  logic wr_data,
  output logic boot_rom_q,
  output logic remap_q
);

  // Strap latch: follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) boot_rom_q <= boot_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     remap_q <= 1'b0;
    else if (wr_en) remap_q <= wr_data;
  end

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import boot_dec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BANK_W      = 4,
  parameter int REGION_W    = 20,
  parameter int N_EXT       = 8,
  parameter int PERIPH_BANK = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              remap,
  input  logic              boot_rom,
  output route_t            route
);

  localparam int SUB_W = ADDR_W - BANK_W - REGION_W;

  logic [BANK_W-1:0] bank;
  logic [SUB_W-1:0]  sub;

  assign bank = addr[ADDR_W-1 -: BANK_W];
  assign sub  = addr[REGION_W +: SUB_W];

  always_comb begin
    route = fixed_route(TGT_ABORT);
    if (int'(bank) == 0) begin
      case (int'(sub))
        SUB_BOOT:  route = boot_route(remap, boot_rom);
        SUB_ROM:   route = fixed_route(TGT_ROM);
        SUB_SRAM0: route = fixed_route(TGT_SRAM0);
        SUB_SRAM1: route = fixed_route(TGT_SRAM1);
        default:   route = fixed_route(TGT_ABORT);
      endcase
    end else if (int'(bank) <= N_EXT) begin
      route.tgt     = TGT_EXT;
      route.ext_idx = 8'(int'(bank) - 1);
    end else if (int'(bank) == PERIPH_BANK) begin
      route = fixed_route(TGT_PERIPH);
    end
  end

endmodule

// File: rtl/target_select.sv
module target_select
  import boot_dec_pkg::*;
#(
  parameter int N_EXT = 8
) (
  input  logic             valid,
  input  route_t           route,
  output logic             sel_rom,
  output logic             sel_sram0,
  output logic             sel_sram1,
  output logic [N_EXT-1:0] sel_ext,
  output logic             sel_periph,
  output logic             abort
);

  assign sel_rom    = valid && (route.tgt == TGT_ROM);
  assign sel_sram0  = valid && (route.tgt == TGT_SRAM0);
  assign sel_sram1  = valid && (route.tgt == TGT_SRAM1);
  assign sel_periph = valid && (route.tgt == TGT_PERIPH);
  assign abort      = valid && (route.tgt == TGT_ABORT);

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign sel_ext[g] = valid && (route.tgt == TGT_EXT) && (route.ext_idx == 8'(g));
  end

endmodule

// File: rtl/boot_addr_decoder.sv
module boot_addr_decoder
  import boot_dec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BANK_W      = 4,
  parameter int REGION_W    = 20,
  parameter int N_EXT       = 8,
  parameter int PERIPH_BANK = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_pin,
  input  logic              remap_wr_en,
  input  logic              remap_wr_data,
  input  logic              xfer_valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_rom,
  output logic              sel_sram0,
  output logic              sel_sram1,
  output logic [N_EXT-1:0]  sel_ext,
  output logic              sel_periph,
  output logic              abort
);

  localparam int SUB_W = ADDR_W - BANK_W - REGION_W;

  // Named internal events for the assertions
  logic   boot_rom_q;
  logic   remap_q;
  route_t route;
  logic   in_boot_window;
  logic   in_periph_bank;
  logic   in_ext_bank;

  assign in_boot_window = (addr[ADDR_W-1 -: BANK_W] == '0) && (addr[REGION_W +: SUB_W] == '0);
  assign in_periph_bank = int'(addr[ADDR_W-1 -: BANK_W]) == PERIPH_BANK;
  assign in_ext_bank    = (int'(addr[ADDR_W-1 -: BANK_W]) >= 1) &&
                          (int'(addr[ADDR_W-1 -: BANK_W]) <= N_EXT);

  boot_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_pin   (boot_pin),
    .wr_en      (remap_wr_en),
    .wr_data    (remap_wr_data),
    .boot_rom_q (boot_rom_q),
    .remap_q    (remap_q)
  );

  bank_decoder #(
    .ADDR_W      (ADDR_W),
    .BANK_W      (BANK_W),
    .REGION_W    (REGION_W),
    .N_EXT       (N_EXT),
    .PERIPH_BANK (PERIPH_BANK)
  ) u_bank (
    .addr     (addr),
    .remap    (remap_q),
    .boot_rom (boot_rom_q),
    .route    (route)
  );

  target_select #(
    .N_EXT (N_EXT)
  ) u_sel (
    .valid      (xfer_valid),
    .route      (route),
    .sel_rom    (sel_rom),
    .sel_sram0  (sel_sram0),
    .sel_sram1  (sel_sram1),
    .sel_ext    (sel_ext),
    .sel_periph (sel_periph),
    .abort      (abort)
  );

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |-> ({sel_rom, sel_sram0, sel_sram1, sel_ext, sel_periph, abort} == '0)); // R11

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> ($countones({sel_rom, sel_sram0, sel_sram1, sel_ext, sel_periph, abort}) == 1)); // R12

  AST_PERIPH_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && in_periph_bank) |-> sel_periph); // R2

  AST_EXT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && in_ext_bank) |-> ($countones(sel_ext) == 1)); // R1

  AST_REMAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && in_boot_window && remap_q) |-> sel_sram0); // R8

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_rom_q)); // R9

  AST_REMAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(remap_wr_en) |-> (remap_q == $past(remap_wr_data))); // R10

endmodule

// File: tb/sim_boot_addr_decoder.sv
module sim_boot_addr_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_pin = 1'b1;
  logic        remap_wr_en = 1'b0;
  logic        remap_wr_data = 1'b0;
  logic        xfer_valid = 1'b0;
  logic [31:0] addr = '0;
  logic        sel_rom, sel_sram0, sel_sram1, sel_periph, abort;
  logic [7:0]  sel_ext;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Bench-side view of the steering controls
  logic m_remap = 1'b0;
  logic m_boot  = 1'b1;

  always #2.5 clk = ~clk;

  boot_addr_decoder u0 (
    .clk (clk), .rst_n (rst_n), .boot_pin (boot_pin),
    .remap_wr_en (remap_wr_en), .remap_wr_data (remap_wr_data),
    .xfer_valid (xfer_valid), .addr (addr),
    .sel_rom (sel_rom), .sel_sram0 (sel_sram0), .sel_sram1 (sel_sram1),
    .sel_ext (sel_ext), .sel_periph (sel_periph), .abort (abort)
  );

  // Vector order: {abort, periph, ext[7:0], sram1, sram0, rom}
  function automatic logic [12:0] expect_sel(logic [31:0] a, logic v, logic rm, logic bt);
    int bank = int'(a[31:28]);
    int sub  = int'(a[27:20]);
    logic [12:0] e = '0;
    if (!v) return e;
    if (bank == 0) begin
      if (sub == 0)      e = rm ? 13'h2 : (bt ? 13'h1 : 13'h8);
      else if (sub == 1) e = 13'h1;
      else if (sub == 2) e = 13'h2;
      else if (sub == 3) e = 13'h4;
      else               e = 13'h1000;
    end else if (bank <= 8) e = 13'(1) << (bank + 2);
    else if (bank == 15)    e = 13'h800;
    else                    e = 13'h1000;
    return e;
  endfunction

  function automatic string req_of(logic [31:0] a, logic v, logic rm, logic bt);
    int bank = int'(a[31:28]);
    int sub  = int'(a[27:20]);
    if (!v) return "R11";
    if (bank == 0) begin
      if (sub == 0) return rm ? "R8" : (bt ? "R6" : "R7");
      if (sub <= 3) return "R4";
      return "R5";
    end
    if (bank <= 8)  return "R1";
    if (bank == 15) return "R2";
    return "R3";
  endfunction

  function automatic logic [12:0] actual();
    return {abort, sel_periph, sel_ext, sel_sram1, sel_sram0, sel_rom};
  endfunction

  // Drive at the falling edge, sample 1 ns later
  task automatic probe(input logic [31:0] a, input logic v, input string tag);
    logic [12:0] e;
    string t;
    @(negedge clk);
    addr = a; xfer_valid = v;
    #1;
    e = expect_sel(a, v, m_remap, m_boot);
    t = (tag == "") ? req_of(a, v, m_remap, m_boot) : tag;
    n_checks++;
    if (actual() !== e) begin
      n_fail++;
      $display("FAIL %s addr=%h valid=%0b actual=%h expected=%h", t, a, v, actual(), e);
    end
    n_checks++;
    if ($countones(actual()) != (v ? 1 : 0)) begin
      n_fail++;
      $display("FAIL R12 addr=%h active=%0d expected=%0d", a, $countones(actual()), v ? 1 : 0);
    end
  endtask

  task automatic write_remap(input logic val, input logic en);
    @(negedge clk);
    remap_wr_en = en; remap_wr_data = val;
    @(posedge clk);
    if (en) m_remap = val;
    @(negedge clk);
    remap_wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst_n = 1'b0; boot_pin = pin; xfer_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_boot = pin; m_remap = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset(1'b1);
    // Reset state: remap 0, strap 1 -> window on ROM (R10, R6)
    probe(32'h0000_0000, 1'b1, "R10");
    probe(32'h0000_0000, 1'b0, "R11");
    probe(32'h000F_FFFF, 1'b1, "R6");
    // Fixed aliases and range edges
    probe(32'h0010_0000, 1'b1, "R4");
    probe(32'h002A_BCDE, 1'b1, "R4");
    probe(32'h003F_FFFF, 1'b1, "R4");
    probe(32'h0040_0000, 1'b1, "R5");
    probe(32'h0FF0_0000, 1'b1, "R5");
    probe(32'h1000_0000, 1'b1, "R1");
    probe(32'h8FFF_FFFF, 1'b1, "R1");
    probe(32'h9000_0000, 1'b1, "R3");
    probe(32'hEFFF_FFFF, 1'b1, "R3");
    probe(32'hF000_0000, 1'b1, "R2");
    // Strap changes after reset are ignored (R9)
    @(negedge clk); boot_pin = 1'b0;
    repeat (4) @(posedge clk);
    probe(32'h0000_1234, 1'b1, "R9");
    // Write with enable low has no effect (R10)
    write_remap(1'b1, 1'b0);
    probe(32'h0000_0000, 1'b1, "R10");
    write_remap(1'b1, 1'b1);
    probe(32'h0000_0000, 1'b1, "R8");
    probe(32'h0010_0000, 1'b1, "R4");
    write_remap(1'b0, 1'b1);
    probe(32'h0000_0000, 1'b1, "R10");
    // New reset with strap 0 -> window on chip select 0
    do_reset(1'b0);
    probe(32'h0000_0000, 1'b1, "R7");
    probe(32'h0000_0040, 1'b1, "R7");
    @(negedge clk); boot_pin = 1'b1;
    repeat (3) @(posedge clk);
    probe(32'h0000_0000, 1'b1, "R9");
    write_remap(1'b1, 1'b1);
    probe(32'h0000_0000, 1'b1, "R8");
    probe(32'h0010_0000, 1'b1, "R4");
    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      logic v;
      if (($urandom % 16) == 0) write_remap(1'($urandom), 1'b1);
      a = $urandom;
      if (($urandom % 2) == 0) begin
        a[31:28] = 4'h0;
        if (($urandom % 4) != 0) a[27:20] = 8'($urandom % 6);
      end
      v = (($urandom % 8) != 0);
      probe(a, v, "");
    end
    summary();
  end

endmodule